// File: doc/BRIEF.md
# Sweep Trigger Controller

This block decides, cycle by cycle, when the sweep of a time-base unit may start. It takes a trigger comparator bit that has already been sampled into the clock domain and a slope select. From these it drives an active-high sweep start gate and an active-low unblank (Z-axis) gate. The two outputs always move together. Sweep generation, analog trigger conditioning and the display sit outside the block. The block only tells the ramp when to run and the display when to light the trace.

Three sweep modes are supported. Normal mode waits for a qualifying edge. Auto mode free-runs once no edge has been seen for a programmable number of idle cycles. Single mode accepts one edge per arm pulse. Every sweep is closed by a sweep-end strobe, which is followed by a programmable holdoff interval; during holdoff the block ignores triggers so that the ramp can settle. A delay-start strobe can also open a sweep, but only when the delay mode select reads "start after delay", and never during holdoff.

Top module: `sweep_trig_ctrl`

## Requirements
- R1: A synchronous active-high reset leaves the block idle: sweep_gate 0, unblank_n 1, holdoff_active 0, single_ready 0.
- R2: With slope_neg 0, a 0-to-1 change of trig_in seen at a clock edge while the block is idle drives sweep_gate high and unblank_n low together, from the cycle after that edge.
- R3: With slope_neg 1, a 1-to-0 change of trig_in is the qualifying event and a 0-to-1 change starts nothing.
- R4: In normal mode (sweep_mode 0, and also 3), a steady trig_in level or a change in the non-selected direction leaves sweep_gate low.
- R5: Once started, a sweep stays active until sweep_end is seen, whatever trig_in does in the meantime.
- R6: sweep_end seen during a sweep ends it at the next cycle. holdoff_active is then high for exactly HOLDOFF_CYCLES cycles, with sweep_gate low and unblank_n high, and after that the block returns to idle.
- R7: While holdoff_active is high, trigger edges and delay-start strobes start no sweep, and none of them is stored for later.
- R8: In auto mode (sweep_mode 1), a sweep starts on its own AUTO_TIMEOUT cycles after the block becomes idle (after holdoff or after entering auto mode) when no qualifying edge arrives first.
- R9: With delay_mode 2 (start after delay), a high delay_start while idle starts a sweep from the next cycle without any trigger edge.
- R10: With delay_mode 0 (independent) or 1 (triggerable after delay), delay_start has no effect on the outputs.
- R11: In single mode (sweep_mode 2), an arm pulse raises single_ready in the next cycle. An unarmed edge starts nothing. An armed edge starts one sweep and clears single_ready in the same cycle the gate rises.
- R12: An arm pulse while not in single mode is ignored: single_ready stays low and nothing carries over into single mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_in | input | 1 | Sampled trigger comparator bit |
| slope_neg | input | 1 | 0: rising change qualifies, 1: falling change qualifies |
| sweep_mode | input | 2 | 0 normal, 1 auto, 2 single, 3 normal |
| delay_mode | input | 2 | 0 independent, 1 triggerable after delay, 2 start after delay, 3 independent |
| delay_start | input | 1 | Delay-elapsed strobe from the delaying time base |
| sweep_end | input | 1 | Strobe marking the end of the running sweep |
| single_arm | input | 1 | Arm pulse for single mode |
| sweep_gate | output | 1 | Sweep start gate, active high |
| unblank_n | output | 1 | Z-axis unblank gate, active low |
| holdoff_active | output | 1 | High during the post-sweep holdoff |
| single_ready | output | 1 | High while single mode is armed |

## Verification
Every output comes from a register, so an edge, strobe or arm pulse presented at one clock edge shows at the outputs from the following cycle on. Holdoff entry is likewise due one cycle after sweep_end, holdoff exit HOLDOFF_CYCLES cycles after that, and an auto sweep AUTO_TIMEOUT cycles after the block becomes idle. The driver tasks stamp each expected output word with the absolute cycle in which it is due, counting these registers. The monitor compares only on falling clock edges and only the items stamped for the current cycle.

// File: rtl/sweep_trig_pkg.sv
package sweep_trig_pkg;

  typedef enum logic [1:0] {
    MODE_NORM   = 2'd0,
    MODE_AUTO   = 2'd1,
    MODE_SINGLE = 2'd2,
    MODE_NORM_B = 2'd3
  } sweep_mode_e;

  typedef enum logic [1:0] {
    DLY_INDEP       = 2'd0,
    DLY_TRIG_AFTER  = 2'd1,
    DLY_START_AFTER = 2'd2,
    DLY_INDEP_B     = 2'd3
  } delay_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SWEEP = 2'd1,
    ST_HOLD  = 2'd2
  } ctrl_state_e;

  // Edge qualification: selected direction of change between two samples.
  function automatic logic slope_edge(input logic prev, input logic cur, input logic neg);
    return neg ? (prev & ~cur) : (~prev & cur);
  endfunction

  // A down counter that reaches zero after n cycles starts from n-1.
  function automatic int unsigned count_load(input int unsigned n);
    return (n == 0) ? 0 : n - 1;
  endfunction

  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/sweep_edge_qual.sv
module sweep_edge_qual
  import sweep_trig_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic trig_in,
  input  logic slope_neg,
  output logic trig_evt
);
  logic prev_q;
  logic primed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q   <= 1'b0;
      primed_q <= 1'b0;
    end else begin
      prev_q   <= trig_in;
      primed_q <= 1'b1;
    end
  end

  // The first sample after reset has no valid predecessor.
  assign trig_evt = primed_q && slope_edge(prev_q, trig_in, slope_neg);
endmodule

// File: rtl/sweep_down_cnt.sv
module sweep_down_cnt #(
  parameter int W = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         en,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= RST_VAL;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (en && (cnt_q != '0)) begin
      cnt_q <= cnt_q - W'(1);
    end
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/sweep_single_arm.sv
module sweep_single_arm (
  input  logic clk,
  input  logic rst,
  input  logic is_single,
  input  logic arm,
  input  logic consume,
  output logic ready
);
  logic ready_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ready_q <= 1'b0;
    end else if (consume || !is_single) begin
      ready_q <= 1'b0;
    end else if (arm) begin
      ready_q <= 1'b1;
    end
  end

  assign ready = ready_q;
endmodule

// File: rtl/sweep_trig_ctrl.sv
module sweep_trig_ctrl
  import sweep_trig_pkg::*;
#(
  parameter int HOLDOFF_CYCLES = 16,
  parameter int AUTO_TIMEOUT   = 64
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       trig_in,
  input  logic       slope_neg,
  input  logic [1:0] sweep_mode,
  input  logic [1:0] delay_mode,
  input  logic       delay_start,
  input  logic       sweep_end,
  input  logic       single_arm,
  output logic       sweep_gate,
  output logic       unblank_n,
  output logic       holdoff_active,
  output logic       single_ready
);
  localparam int LONGEST = (HOLDOFF_CYCLES > AUTO_TIMEOUT) ? HOLDOFF_CYCLES : AUTO_TIMEOUT;
  localparam int CNT_W   = cnt_width(LONGEST);
  localparam logic [CNT_W-1:0] HOLD_LOAD = CNT_W'(count_load(HOLDOFF_CYCLES));
  localparam logic [CNT_W-1:0] AUTO_LOAD = CNT_W'(count_load(AUTO_TIMEOUT));

  ctrl_state_e state_q, state_d;

  // Named internal events.
  logic trig_evt;
  logic in_idle, in_sweep, in_hold;
  logic is_auto, is_single;
  logic delay_ok, gate_ok, auto_fire, start_ok;
  logic hold_zero, hold_load, auto_zero, auto_en;
  logic consume;

  assign in_idle   = (state_q == ST_IDLE);
  assign in_sweep  = (state_q == ST_SWEEP);
  assign in_hold   = (state_q == ST_HOLD);
  assign is_auto   = (sweep_mode == MODE_AUTO);
  assign is_single = (sweep_mode == MODE_SINGLE);

  sweep_edge_qual edge_i (
    .clk      (clk),
    .rst      (rst),
    .trig_in  (trig_in),
    .slope_neg(slope_neg),
    .trig_evt (trig_evt)
  );

  assign hold_load = in_sweep && sweep_end;

  sweep_down_cnt #(.W(CNT_W), .RST_VAL('0)) hold_cnt_i (
    .clk     (clk),
    .rst     (rst),
    .load    (hold_load),
    .load_val(HOLD_LOAD),
    .en      (in_hold),
    .zero    (hold_zero)
  );

  assign auto_en = in_idle && is_auto && !trig_evt;

  sweep_down_cnt #(.W(CNT_W), .RST_VAL(AUTO_LOAD)) auto_cnt_i (
    .clk     (clk),
    .rst     (rst),
    .load    (!auto_en),
    .load_val(AUTO_LOAD),
    .en      (auto_en),
    .zero    (auto_zero)
  );

  assign delay_ok  = (delay_mode == DLY_START_AFTER) && delay_start;
  assign gate_ok   = !is_single || single_ready;
  assign auto_fire = in_idle && is_auto && auto_zero;
  assign start_ok  = in_idle && ((((trig_evt || delay_ok) && gate_ok)) || auto_fire);
  assign consume   = start_ok && is_single;

  sweep_single_arm arm_i (
    .clk      (clk),
    .rst      (rst),
    .is_single(is_single),
    .arm      (single_arm),
    .consume  (consume),
    .ready    (single_ready)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_ok)  state_d = ST_SWEEP;
      ST_SWEEP: if (sweep_end) state_d = ST_HOLD;
      ST_HOLD:  if (hold_zero) state_d = ST_IDLE;
      default:                 state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

  assign sweep_gate     = in_sweep;
  assign unblank_n      = !in_sweep;
  assign holdoff_active = in_hold;
endmodule

// File: rtl/sweep_trig_chk.sv
module sweep_trig_chk
  import sweep_trig_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic [1:0] sweep_mode,
  input logic [1:0] delay_mode,
  input logic       delay_start,
  input logic       sweep_end,
  input logic       trig_evt,
  input logic       auto_fire,
  input logic       sweep_gate,
  input logic       unblank_n,
  input logic       holdoff_active,
  input logic       single_ready
);
  p_gate_unblank_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(sweep_gate) |-> $fell(unblank_n));

  p_norm_needs_cause_r4: assert property (@(posedge clk) disable iff (rst)
    ($rose(sweep_gate) && ($past(sweep_mode) == MODE_NORM)) |->
      $past(trig_evt || (delay_start && (delay_mode == DLY_START_AFTER))));

  p_sweep_persists_r5: assert property (@(posedge clk) disable iff (rst)
    (sweep_gate && !sweep_end) |=> sweep_gate);

  p_holdoff_entry_r6: assert property (@(posedge clk) disable iff (rst)
    (sweep_gate && sweep_end) |=> (holdoff_active && !sweep_gate && unblank_n));

  p_holdoff_blocks_r7: assert property (@(posedge clk) disable iff (rst)
    holdoff_active |=> !sweep_gate);

  p_delay_ignored_r10: assert property (@(posedge clk) disable iff (rst)
    (!sweep_gate && !holdoff_active && delay_start && (delay_mode != DLY_START_AFTER)
     && !trig_evt && !auto_fire) |=> !sweep_gate);

  p_single_consumed_r11: assert property (@(posedge clk) disable iff (rst)
    ($rose(sweep_gate) && ($past(sweep_mode) == MODE_SINGLE)) |->
      ($past(single_ready) && !single_ready));
endmodule

bind sweep_trig_ctrl sweep_trig_chk chk_i (
  .clk           (clk),
  .rst           (rst),
  .sweep_mode    (sweep_mode),
  .delay_mode    (delay_mode),
  .delay_start   (delay_start),
  .sweep_end     (sweep_end),
  .trig_evt      (trig_evt),
  .auto_fire     (auto_fire),
  .sweep_gate    (sweep_gate),
  .unblank_n     (unblank_n),
  .holdoff_active(holdoff_active),
  .single_ready  (single_ready)
);

// File: tb/sweep_trig_ctrl_tb_top.sv
`timescale 1ns/1ps
module sweep_trig_ctrl_tb_top;
  localparam int H = 8;
  localparam int T = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic trig_in = 1'b0, slope_neg = 1'b0;
  logic [1:0] sweep_mode = 2'd0, delay_mode = 2'd0;
  logic delay_start = 1'b0, sweep_end = 1'b0, single_arm = 1'b0;
  logic sweep_gate, unblank_n, holdoff_active, single_ready;

  always #2.5 clk = ~clk;

  sweep_trig_ctrl #(.HOLDOFF_CYCLES(H), .AUTO_TIMEOUT(T)) dut_i (
    .clk(clk), .rst(rst), .trig_in(trig_in), .slope_neg(slope_neg),
    .sweep_mode(sweep_mode), .delay_mode(delay_mode), .delay_start(delay_start),
    .sweep_end(sweep_end), .single_arm(single_arm), .sweep_gate(sweep_gate),
    .unblank_n(unblank_n), .holdoff_active(holdoff_active), .single_ready(single_ready)
  );

  typedef struct {
    int       cyc;
    logic [3:0] exp;
    string    tag;
  } item_t;

  item_t q[$];
  int cyc = 0;
  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: compare items due in this cycle, away from the active edge.
  always @(negedge clk) begin
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].cyc == cyc) begin
        n_checks++;
        if ({sweep_gate, unblank_n, holdoff_active, single_ready} !== q[i].exp) begin
          n_fail++;
          $display("FAIL %s: {gate,unblank_n,holdoff,ready} actual %b expected %b (cycle %0d)",
                   q[i].tag, {sweep_gate, unblank_n, holdoff_active, single_ready},
                   q[i].exp, cyc);
        end
        q.delete(i);
      end
    end
  end

  // Driver side: push an expected output word due delta cycles from now.
  task automatic push(input int delta, input logic g, input logic u,
                      input logic h, input logic r, input string tag);
    item_t it;
    it.cyc = cyc + delta;
    it.exp = {g, u, h, r};
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Close the running sweep and walk through the holdoff interval.
  task automatic end_sweep(input logic rdy);
    sweep_end = 1'b1;
    push(1, 1'b0, 1'b1, 1'b1, rdy, "R6 holdoff first cycle");
    push(H, 1'b0, 1'b1, 1'b1, rdy, "R6 holdoff last cycle");
    push(H + 1, 1'b0, 1'b1, 1'b0, rdy, "R6 back to idle");
    step(1);
    sweep_end = 1'b0;
    step(H + 1);
  endtask

  initial begin
    step(3);
    rst = 1'b0;
    push(1, 1'b0, 1'b1, 1'b0, 1'b0, "R1 reset state");
    step(2);

    // R2: rising edge, positive slope
    trig_in = 1'b1;
    push(1, 1'b1, 1'b0, 1'b0, 1'b0, "R2 rising edge starts sweep");
    step(2);
    // R5: toggling trigger during sweep
    trig_in = 1'b0; step(1);
    trig_in = 1'b1;
    push(1, 1'b1, 1'b0, 1'b0, 1'b0, "R5 sweep held through trigger activity");
    step(2);

    // R6/R7: holdoff, with edge and delay strobe inside it
    trig_in = 1'b0;
    sweep_end = 1'b1;
    push(1, 1'b0, 1'b1, 1'b1, 1'b0, "R6 holdoff first cycle");
    push(H, 1'b0, 1'b1, 1'b1, 1'b0, "R6 holdoff last cycle");
    push(H + 1, 1'b0, 1'b1, 1'b0, 1'b0, "R6 back to idle");
    step(1);
    sweep_end = 1'b0;
    trig_in = 1'b1;
    delay_mode = 2'd2;
    delay_start = 1'b1;
    push(1, 1'b0, 1'b1, 1'b1, 1'b0, "R7 edge and delay strobe in holdoff");
    step(1);
    delay_start = 1'b0;
    delay_mode = 2'd0;
    step(H);
    push(1, 1'b0, 1'b1, 1'b0, 1'b0, "R7 edge from holdoff not stored");
    push(2, 1'b0, 1'b1, 1'b0, 1'b0, "R4 steady high level starts nothing");
    step(2);
    trig_in = 1'b0;
    push(1, 1'b0, 1'b1, 1'b0, 1'b0, "R4 falling change ignored on positive slope");
    step(2);

    // R3: negative slope
    slope_neg = 1'b1;
    step(1);
    trig_in = 1'b1;
    push(1, 1'b0, 1'b1, 1'b0, 1'b0, "R3 rising ignored on negative slope");
    step(2);
    trig_in = 1'b0;
    push(1, 1'b1, 1'b0, 1'b0, 1'b0, "R3 falling starts sweep");
    step(2);
    end_sweep(1'b0);
    slope_neg = 1'b0;
    step(1);

    // R10 then R9: delay strobe per delay mode
    delay_mode = 2'd0;
    delay_start = 1'b1;
    push(1, 1'b0, 1'b1, 1'b0, 1'b0, "R10 delay strobe ignored in mode 0");
    step(1);
    delay_mode = 2'd1;
    push(1, 1'b0, 1'b1, 1'b0, 1'b0, "R10 delay strobe ignored in mode 1");
    step(1);
    delay_mode = 2'd2;
    push(1, 1'b1, 1'b0, 1'b0, 1'b0, "R9 delay strobe starts sweep in mode 2");
    step(1);
    delay_start = 1'b0;
    delay_mode = 2'd0;
    push(1, 1'b1, 1'b0, 1'b0, 1'b0, "R9 sweep held after strobe drops");
    step(2);
    end_sweep(1'b0);

    // R12: arm outside single mode
    single_arm = 1'b1;
    push(1, 1'b0, 1'b1, 1'b0, 1'b0, "R12 arm ignored in normal mode");
    step(1);
    single_arm = 1'b0;
    step(1);
    sweep_mode = 2'd2;
    push(1, 1'b0, 1'b1, 1'b0, 1'b0, "R12 no arm carried into single mode");
    step(1);
    trig_in = 1'b1;
    push(1, 1'b0, 1'b1, 1'b0, 1'b0, "R11 unarmed edge ignored");
    step(2);
    trig_in = 1'b0;
    step(2);

    // R11: armed single sweep
    single_arm = 1'b1;
    push(1, 1'b0, 1'b1, 1'b0, 1'b1, "R11 arm raises ready");
    step(1);
    single_arm = 1'b0;
    trig_in = 1'b1;
    push(1, 1'b1, 1'b0, 1'b0, 1'b0, "R11 armed edge starts sweep, ready cleared");
    step(2);
    trig_in = 1'b0;
    end_sweep(1'b0);
    trig_in = 1'b1;
    push(1, 1'b0, 1'b1, 1'b0, 1'b0, "R11 second edge needs new arm");
    step(2);
    trig_in = 1'b0;
    step(1);

    // R8: auto free-run, from mode entry and from holdoff end
    sweep_mode = 2'd1;
    push(T - 1, 1'b0, 1'b1, 1'b0, 1'b0, "R8 no sweep before timeout");
    push(T, 1'b1, 1'b0, 1'b0, 1'b0, "R8 auto sweep at timeout");
    step(T);
    push(H + T, 1'b0, 1'b1, 1'b0, 1'b0, "R8 idle just before timeout after holdoff");
    push(H + 1 + T, 1'b1, 1'b0, 1'b0, 1'b0, "R8 auto sweep timed from holdoff end");
    end_sweep(1'b0);
    step(T);
    sweep_mode = 2'd0;
    end_sweep(1'b0);
    step(3);

    if (q.size() != 0) begin
      n_checks++;
      n_fail++;
      $display("FAIL scoreboard: actual %0d items left, expected 0", q.size());
    end
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout, expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule